// File: doc/BRIEF.md
# Mixed-Width I2C Register Bank

This block is an I2C target that holds a small configuration space. Most locations are one byte wide. Two locations are 32-bit words, and a word changes only after its complete four-byte burst has arrived. A host selects a location by writing a pointer byte after the target address. On a write, the data bytes follow the pointer. On a read, the host writes the pointer, issues a repeated start and clocks out as many bytes as the selected location holds, most significant byte first.

All stored contents leave the block as parallel vectors for the surrounding datapath. One location reads back a live status input instead of stored data. Another location returns a fixed identification byte. The reserved locations neither store nor return anything.

The bus lines are sampled with the system clock. The data line is driven only by pulling it low through an output enable.

Top module: `mwreg_i2c_bank`

## Requirements
- R1: A frame is acknowledged only when its 7-bit address equals the TARGET_ADDR parameter (default 0x36). For any other address the target never pulls SDA low until the next start.
- R2: After the pointer byte, the first data byte is stored in a writable one-byte location (0x00, 0x03–0x0E, 0x10, 0x18–0x1C). Further bytes in the same burst leave every location unchanged.
- R3: A 32-bit location (0x20 and 0x25) takes a new value only when four data bytes arrive after its pointer in one write, first byte as bits 31:24. A burst with fewer bytes leaves the location unchanged.
- R4: Location 0x01 always reads 0x03, and writes to it are ignored.
- R5: Reserved locations (0x0F, 0x11–0x17, 0x1D–0x1F) and any pointer at or above 0x1D other than the two wide ones read as 0x00. Writes to them change nothing.
- R6: Location 0x02 returns the value on the status input at the time its byte is loaded for transmission.
- R7: After reset the one-byte locations hold 0x00=0x6C, 0x03=0xA0, 0x04=0x05, 0x05=0x60, 0x07=0xFF, 0x08–0x0D=0x30, 0x18=0x3F, 0x1A=0x18, 0x1B=0x82 and 0x1C=0x05. All other locations hold 0x00.
- R8: A read returns the bytes of the selected location most significant first. Bytes clocked beyond its width are 0x00. A read stopped early by a host NACK has no side effect.
- R9: Synchronous active-high reset restores every default and drops any partially received wide burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe_o | output | 1 | Pull SDA low when high |
| status_i | input | 8 | Live status byte returned at location 0x02 |
| narrow_o | output | NARROW_N*8 | One-byte locations, location n at bits 8n+7:8n |
| wide_o | output | WIDE_N*32 | 32-bit locations, k-th at bits 32k+31:32k (0x20 first) |

## Verification
On every cycle, the assertions check three things: a wide word changes only on the fourth byte of a burst, reserved slots never move, and the target stays off the data line while it is idle or receiving an address. They also check that the identification and status bytes are what get loaded for transmission, and that the read byte index stays bounded. Some behaviour shows only in the bench's bus scenarios: byte ordering across a burst, the zero filler past a location's width, partial-burst discard across a reset, and the NACK toward a foreign address.

// File: rtl/mwreg_pkg.sv
package mwreg_pkg;
  localparam int NARROW_N = 29;
  localparam int WIDE_N   = 2;
  localparam logic [7:0] WIDE_ADDR [WIDE_N] = '{8'h20, 8'h25};
  localparam logic [7:0] ID_ADDR     = 8'h01;
  localparam logic [7:0] STATUS_ADDR = 8'h02;
  localparam logic [7:0] ID_VALUE    = 8'h03;

  function automatic logic is_reserved(input logic [7:0] a);
    return (a == 8'h0F) || (a >= 8'h11 && a <= 8'h17) || (a >= 8'h1D && a <= 8'h1F);
  endfunction

  function automatic logic [7:0] reset_value(input logic [7:0] a);
    case (a)
      8'h00: return 8'h6C;
      8'h01: return ID_VALUE;
      8'h03: return 8'hA0;
      8'h04: return 8'h05;
      8'h05: return 8'h60;
      8'h07: return 8'hFF;
      8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: return 8'h30;
      8'h18: return 8'h3F;
      8'h1A: return 8'h18;
      8'h1B: return 8'h82;
      8'h1C: return 8'h05;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/mwreg_link.sv
module mwreg_link #(
  parameter logic [6:0] TARGET_ADDR = 7'h36
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       begin_o,
  output logic       rw_o,
  output logic       byte_v_o,
  output logic [7:0] byte_o,
  output logic       tx_load_o,
  input  logic [7:0] tx_byte_i
);
  typedef enum logic [2:0] {L_IDLE, L_ADDR, L_AACK, L_RX, L_RACK, L_TX, L_MACK} link_st_t;
  link_st_t   state;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic [7:0] sh;
  logic [3:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];          sda_d  <= sda_sy[1];
    end
  end

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  assign tx_load_o = scl_fall && !start_det && !stop_det &&
                     ((state == L_AACK && rw_o) || state == L_MACK);
  assign byte_o = sh;

  always_ff @(posedge clk) begin
    begin_o  <= 1'b0;
    byte_v_o <= 1'b0;
    if (rst) begin
      state <= L_IDLE; sh <= '0; bcnt <= '0; rw_o <= 1'b0; sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state <= L_IDLE; sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state <= L_ADDR; bcnt <= '0; sda_oe_o <= 1'b0;
    end else if (scl_rise) begin
      if (state == L_ADDR || state == L_RX) begin
        sh <= {sh[6:0], sda_s}; bcnt <= bcnt + 4'd1;
      end else if (state == L_MACK && sda_s) begin
        state <= L_IDLE;
      end
    end else if (scl_fall) begin
      case (state)
        L_ADDR: if (bcnt == 4'd8) begin
          if (sh[7:1] == TARGET_ADDR) begin
            sda_oe_o <= 1'b1; rw_o <= sh[0]; begin_o <= 1'b1; state <= L_AACK;
          end else state <= L_IDLE;
        end
        L_RX: if (bcnt == 4'd8) begin
          sda_oe_o <= 1'b1; byte_v_o <= 1'b1; state <= L_RACK;
        end
        L_AACK, L_RACK: if (tx_load_o) begin
          sh <= tx_byte_i; sda_oe_o <= ~tx_byte_i[7]; bcnt <= 4'd1; state <= L_TX;
        end else begin
          sda_oe_o <= 1'b0; bcnt <= '0; state <= L_RX;
        end
        L_TX: if (bcnt == 4'd8) begin
          sda_oe_o <= 1'b0; state <= L_MACK;
        end else begin
          sda_oe_o <= ~sh[6]; sh <= {sh[6:0], 1'b0}; bcnt <= bcnt + 4'd1;
        end
        L_MACK: begin
          sh <= tx_byte_i; sda_oe_o <= ~tx_byte_i[7]; bcnt <= 4'd1; state <= L_TX;
        end
        default: state <= L_IDLE;
      endcase
    end
  end

  // R1: no pull on SDA while idle or while an address is shifting in
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (state == L_IDLE || state == L_ADDR) |-> !sda_oe_o);
endmodule

// File: rtl/mwreg_store.sv
module mwreg_store
  import mwreg_pkg::*;
#(
  parameter int NARROW = NARROW_N,
  parameter int WIDE   = WIDE_N
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  begin_i,
  input  logic                  rw_i,
  input  logic                  byte_v_i,
  input  logic [7:0]            byte_i,
  input  logic                  tx_load_i,
  output logic [7:0]            tx_byte_o,
  input  logic [7:0]            status_i,
  output logic [NARROW*8-1:0]   narrow_o,
  output logic [WIDE*32-1:0]    wide_o
);
  localparam int AW = $clog2(NARROW);
  localparam logic [7:0] NLIM = 8'(NARROW);

  logic [7:0]  narrow_q [NARROW];
  logic [31:0] wide_q   [WIDE];
  logic [7:0]  ptr;
  logic [2:0]  idx;
  logic        expect_ptr;
  logic [23:0] stage;
  logic [WIDE-1:0] wide_hit;

  wire in_narrow = (ptr < NLIM);
  wire wr_ok     = in_narrow && !is_reserved(ptr) && ptr != ID_ADDR && ptr != STATUS_ADDR;
  wire data_v    = byte_v_i && !expect_ptr;

  for (genvar k = 0; k < WIDE; k++) begin : g_wide
    assign wide_hit[k] = (ptr == WIDE_ADDR[k]);
    assign wide_o[k*32 +: 32] = wide_q[k];
    always_ff @(posedge clk) begin
      if (rst) wide_q[k] <= '0;
      else if (data_v && wide_hit[k] && idx == 3'd3) wide_q[k] <= {stage, byte_i};
    end
    // R3: a wide word moves only on the fourth byte of its burst
    p_wide_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !(data_v && wide_hit[k] && idx == 3'd3) |=> $stable(wide_q[k]));
  end

  for (genvar a = 0; a < NARROW; a++) begin : g_narrow
    assign narrow_o[a*8 +: 8] = narrow_q[a];
    if (is_reserved(8'(a))) begin : g_rsv
      // R5: reserved slots never change
      p_reserved_hold_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(narrow_q[a]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < NARROW; a++) narrow_q[a] <= reset_value(8'(a));
      ptr <= '0; idx <= '0; expect_ptr <= 1'b0; stage <= '0;
    end else if (begin_i) begin
      idx <= '0; expect_ptr <= !rw_i;
    end else if (byte_v_i) begin
      if (expect_ptr) begin
        ptr <= byte_i; expect_ptr <= 1'b0; idx <= '0;
      end else begin
        stage <= {stage[15:0], byte_i};
        if (idx != 3'd4) idx <= idx + 3'd1;
        if (wr_ok && idx == 3'd0) narrow_q[ptr[AW-1:0]] <= byte_i;
      end
    end else if (tx_load_i && idx != 3'd4) begin
      idx <= idx + 3'd1;
    end
  end

  always_comb begin
    tx_byte_o = 8'h00;
    if (in_narrow && idx == 3'd0) begin
      if (ptr == ID_ADDR)               tx_byte_o = ID_VALUE;
      else if (ptr == STATUS_ADDR)      tx_byte_o = status_i;
      else if (!is_reserved(ptr))       tx_byte_o = narrow_q[ptr[AW-1:0]];
    end
    for (int k = 0; k < WIDE; k++)
      if (wide_hit[k] && !idx[2]) tx_byte_o = wide_q[k][{~idx[1:0], 3'b000} +: 8];
  end

  // R4: identification byte is what leaves the bank
  p_id_read_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_load_i && ptr == ID_ADDR && idx == 3'd0) |-> tx_byte_o == 8'h03);
  // R6: status byte is the live input
  p_status_live_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_load_i && ptr == STATUS_ADDR && idx == 3'd0) |-> tx_byte_o == status_i);
  // R8: byte index saturates at the widest location
  p_idx_bound_r8: assert property (@(posedge clk) disable iff (rst) idx <= 3'd4);
endmodule

// File: rtl/mwreg_i2c_bank.sv
module mwreg_i2c_bank
  import mwreg_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h36,
  parameter int NARROW = NARROW_N,
  parameter int WIDE   = WIDE_N
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [7:0]          status_i,
  output logic [NARROW*8-1:0] narrow_o,
  output logic [WIDE*32-1:0]  wide_o
);
  logic       begin_p, rw, byte_v, tx_load;
  logic [7:0] rx_byte, tx_byte;

  mwreg_link #(.TARGET_ADDR(TARGET_ADDR)) u_link (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe_o(sda_oe_o),
    .begin_o(begin_p), .rw_o(rw), .byte_v_o(byte_v), .byte_o(rx_byte),
    .tx_load_o(tx_load), .tx_byte_i(tx_byte));

  mwreg_store #(.NARROW(NARROW), .WIDE(WIDE)) u_store (
    .clk(clk), .rst(rst), .begin_i(begin_p), .rw_i(rw), .byte_v_i(byte_v),
    .byte_i(rx_byte), .tx_load_i(tx_load), .tx_byte_o(tx_byte),
    .status_i(status_i), .narrow_o(narrow_o), .wide_o(wide_o));
endmodule

// File: tb/mwreg_i2c_bank_bench.sv
module mwreg_i2c_bank_bench;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h36;

  logic clk = 1'b0, rst = 1'b1;
  logic m_scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  logic [7:0] status = 8'h00;
  logic [29*8-1:0] narrow;
  logic [63:0] wide;
  wire sda = !(m_low || sda_oe);

  int checks = 0, fails = 0;
  logic [7:0] rbuf [8];
  logic ack;

  always #10 clk = ~clk;

  mwreg_i2c_bank u_mwreg_i2c_bank (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda), .sda_oe_o(sda_oe),
    .status_i(status), .narrow_o(narrow), .wide_o(wide));

  // {pointer, byte written, byte expected on readback}
  localparam logic [23:0] VEC [9] = '{
    {8'h03, 8'h5A, 8'h5A},   // R2
    {8'h1C, 8'hC3, 8'hC3},   // R2
    {8'h00, 8'h00, 8'h00},   // R2
    {8'h10, 8'hFF, 8'hFF},   // R2
    {8'h01, 8'h77, 8'h03},   // R4
    {8'h0F, 8'h11, 8'h00},   // R5
    {8'h14, 8'h22, 8'h00},   // R5
    {8'h1E, 8'h33, 8'h00},   // R5
    {8'h30, 8'h44, 8'h00}    // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic w(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_low = 1'b0; w(); m_scl = 1'b1; w(); m_low = 1'b1; w(); m_scl = 1'b0; w();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; w(); m_scl = 1'b1; w(); m_low = 1'b0; w();
  endtask

  task automatic send(input logic [7:0] b, output logic got_ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; w(); m_scl = 1'b1; w(); w(); m_scl = 1'b0; w();
    end
    m_low = 1'b0; w(); m_scl = 1'b1; w(); got_ack = !sda; w(); m_scl = 1'b0; w();
  endtask

  task automatic recv(input logic last, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      w(); m_scl = 1'b1; w(); b[i] = sda; w(); m_scl = 1'b0;
    end
    m_low = !last; w(); m_scl = 1'b1; w(); w(); m_scl = 1'b0; w(); m_low = 1'b0;
  endtask

  task automatic wr(input logic [7:0] p, input int n, input logic [31:0] d);
    logic a;
    bus_start();
    send({ADDR, 1'b0}, a); send(p, a);
    for (int i = 0; i < n; i++) send(d[31-8*(i%4) -: 8], a);
    bus_stop();
  endtask

  task automatic rd(input logic [7:0] p, input int n);
    logic a;
    bus_start();
    send({ADDR, 1'b0}, a); send(p, a);
    bus_start();
    send({ADDR, 1'b1}, a);
    for (int i = 0; i < n; i++) recv(i == n - 1, rbuf[i]);
    bus_stop();
  endtask

  initial begin
    repeat (2000000 / 10) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk); rst = 1'b0; repeat (4) @(negedge clk);
    // R7 reset defaults at the ports
    chk("R7 0x00", narrow[0*8 +: 8], 8'h6C);
    chk("R7 0x03", narrow[3*8 +: 8], 8'hA0);
    chk("R7 0x07", narrow[7*8 +: 8], 8'hFF);
    chk("R7 0x0B", narrow[11*8 +: 8], 8'h30);
    chk("R7 0x1B", narrow[27*8 +: 8], 8'h82);
    chk("R7 0x06", narrow[6*8 +: 8], 8'h00);
    chk("R7 wide", wide, 64'h0);
    chk("R1 idle release", sda_oe, 1'b0);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][23:16], 1, {VEC[i][15:8], 24'h0});
      rd(VEC[i][23:16], 1);
      chk($sformatf("R2 R4 R5 vector %0d", i), rbuf[0], VEC[i][7:0]);
    end
    chk("R2 port 0x03", narrow[3*8 +: 8], 8'h5A);

    // R1 acknowledge and foreign address
    bus_start(); send({ADDR, 1'b0}, ack); chk("R1 own ack", ack, 1'b1); bus_stop();
    bus_start(); send({7'h35, 1'b0}, ack); chk("R1 foreign nack", ack, 1'b0);
    send(8'h03, ack); send(8'h99, ack); bus_stop();
    chk("R1 foreign no write", narrow[3*8 +: 8], 8'h5A);

    // R2 extra bytes after a narrow location are dropped
    wr(8'h05, 3, 32'h11_22_33_00);
    chk("R2 first byte", narrow[5*8 +: 8], 8'h11);
    chk("R2 next slot untouched", narrow[6*8 +: 8], 8'h00);

    // R3 full burst commits MSB first; R8 readback order and filler
    wr(8'h20, 4, 32'h11223344);
    chk("R3 wide commit", wide[31:0], 32'h11223344);
    rd(8'h20, 5);
    chk("R8 read msb first", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h11223344);
    chk("R8 past width", rbuf[4], 8'h00);
    wr(8'h25, 3, 32'hAABBCC00);
    chk("R3 partial ignored", wide[63:32], 32'h0);
    wr(8'h25, 4, 32'hDEADBEEF);
    chk("R3 second wide", wide[63:32], 32'hDEADBEEF);
    chk("R3 first wide kept", wide[31:0], 32'h11223344);
    rd(8'h25, 2);
    chk("R8 early stop", {rbuf[0], rbuf[1]}, 16'hDEAD);
    rd(8'h03, 1);
    chk("R8 after early stop", rbuf[0], 8'h5A);

    // R6 live status
    status = 8'hA5; rd(8'h02, 1); chk("R6 status A5", rbuf[0], 8'hA5);
    status = 8'h3C; rd(8'h02, 1); chk("R6 status 3C", rbuf[0], 8'h3C);

    // R9 reset in the middle of a wide burst
    bus_start(); send({ADDR, 1'b0}, ack); send(8'h20, ack);
    send(8'h55, ack); send(8'h66, ack);
    @(negedge clk); rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    send(8'h77, ack); send(8'h88, ack); bus_stop();
    chk("R9 wide cleared", wide[31:0], 32'h0);
    chk("R9 narrow default", narrow[3*8 +: 8], 8'hA0);
    wr(8'h20, 2, 32'h99AA0000);
    chk("R9 no stale stage", wide[31:0], 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule